// File: doc/BRIEF.md
# Serial Flash Sector-Erase Command Slave

This block is the device side of a serial flash, cut down to three commands: write-enable, sector-erase and status-read. They arrive on a single-bit SPI link in mode 0: chip select, serial clock, data in and data out. The SPI pins are resynchronised into the system clock domain. The bits of each frame are counted from the falling chip select. The opcode is taken from the first eight bits. A command takes effect only if chip select rises at the exact bit count that its opcode requires.

A valid sector-erase needs the write-enable latch to be set and the target sector to lie outside the protected range. It then starts a self-timed erase cycle whose length is a parameter counted in system clock cycles. While the cycle runs, the status byte shows the write-in-progress flag. The write-enable latch is cleared before the cycle ends. When the cycle ends, every byte of the addressed sector of the on-chip array becomes 0xFF. Protection covers a contiguous group of sectors, set by a count and a choice of direction: counted down from the top sector or up from sector 0.

A side read port lets surrounding logic see the array contents without using SPI.

Top module: `flash_erase_slave`

## Requirements
- R1: A frame of exactly 8 bits carrying opcode 0x06 sets the write-enable latch, which reads as status bit 1.
- R2: After opcode 0x05 the device shifts the status byte {6'b0, WEL, WIP} out MSB first. Each bit changes after a falling serial clock edge. The byte repeats for as long as chip select stays low, and data out reads 0 while chip select is high.
- R3: A frame of exactly 32 bits carrying opcode 0x20 and a 24-bit address, MSB first, starts an erase when the latch is set. The sector index is the address field [SECT_LSB +: SECT_W]. All higher address bits, A23..A20 included, are ignored.
- R4: A frame whose chip select rises at any other bit count than the one its opcode requires (8 for 0x06, 32 for 0x20) is discarded. It changes neither the latch nor the array.
- R5: A sector-erase received while the latch is clear is not executed.
- R6: WIP reads 1 for exactly TSE_CYCLES system cycles. The erased sector reads 0xFF from TSE_CYCLES+3 clock edges after chip select goes high, counting the synchroniser.
- R7: The write-enable latch reads 0 once the erase cycle has finished.
- R8: After an erase every byte of the target sector reads 0xFF, and all other sectors keep their contents.
- R9: Sector s is protected when prot_top_i=1 and s >= NUM_SECTORS - prot_cnt_i, or when prot_top_i=0 and s < prot_cnt_i. An erase aimed at a protected sector is not executed and leaves the latch set.
- R10: While WIP is 1, every command except status-read is ignored.
- R11: After reset WIP and WEL are 0, every array byte is 0x00, and data out is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_n_i | input | 1 | SPI chip select, active low |
| sck_i | input | 1 | SPI serial clock |
| mosi_i | input | 1 | SPI serial data into the device |
| miso_o | output | 1 | SPI serial data out of the device |
| prot_cnt_i | input | SECT_W+1 | Number of protected sectors |
| prot_top_i | input | 1 | 1: protection counts down from the top sector; 0: up from sector 0 |
| rd_addr_i | input | MEM_AW | Byte address for the side read port |
| rd_data_o | output | 8 | Array byte at rd_addr_i |

## Verification
The erase is tried under several conditions, and each one isolates one gate of the commit rule. The conditions are: a correct frame with the latch set, the same frame with the latch clear, a frame one bit short, a write-enable one bit long, a second erase sent while the first is running, and targets that fall inside and outside both top-anchored and bottom-anchored protection. One erase address has A23..A20 set, so an erase of the wrong sector would show up as decoding of the high bits. The bench compares the side read port with a model of the array on every clock. This catches an erase that lands one cycle early or late, and any write that reaches a neighbouring sector. Status reads made during and after an erase tell apart the time when WIP and WEL are set from the time when they are released.

// File: rtl/fes_pkg.sv
package fes_pkg;
  localparam int CNT_W = 6;
  localparam logic [7:0] OP_WREN = 8'h06;
  localparam logic [7:0] OP_RDSR = 8'h05;
  localparam logic [7:0] OP_SE   = 8'h20;
  localparam int WREN_BITS = 8;
  localparam int SE_BITS   = 32;

  typedef enum logic {ST_IDLE, ST_ERASE} erase_state_e;
endpackage

// File: rtl/fes_spi_front.sv
module fes_spi_front
  import fes_pkg::*;
#(
  parameter int SECT_LSB = 4,
  parameter int SECT_W   = 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 cs_n_i,
  input  logic                 sck_i,
  input  logic                 mosi_i,
  input  logic [7:0]           status_i,
  output logic                 miso_o,
  output logic                 cs_hi_o,
  output logic                 frame_end_o,
  output logic [CNT_W-1:0]     bit_cnt_o,
  output logic [7:0]           op_o,
  output logic [SECT_W-1:0]    sector_o
);
  logic [2:0]       cs_sync_q, sck_sync_q;
  logic [1:0]       mosi_sync_q;
  logic             cs_hi, sck_rise, sck_fall, mosi_s;
  logic [CNT_W-1:0] cnt_q;
  logic [31:0]      sr_q;
  logic [7:0]       op_q, op_next;
  logic             rd_act_q;
  logic [2:0]       out_pos_q;
  logic [6:0]       out_sr_q;
  logic             miso_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cs_sync_q   <= 3'b111;
      sck_sync_q  <= 3'b000;
      mosi_sync_q <= 2'b00;
    end else begin
      cs_sync_q   <= {cs_sync_q[1:0], cs_n_i};
      sck_sync_q  <= {sck_sync_q[1:0], sck_i};
      mosi_sync_q <= {mosi_sync_q[0], mosi_i};
    end
  end

  assign cs_hi    = cs_sync_q[1];
  assign sck_rise = sck_sync_q[1] & ~sck_sync_q[2];
  assign sck_fall = ~sck_sync_q[1] & sck_sync_q[2];
  assign mosi_s   = mosi_sync_q[1];
  assign op_next  = {sr_q[6:0], mosi_s};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      sr_q     <= '0;
      op_q     <= '0;
      rd_act_q <= 1'b0;
    end else if (cs_hi) begin
      cnt_q    <= '0;
      rd_act_q <= 1'b0;
    end else if (sck_rise) begin
      sr_q <= {sr_q[30:0], mosi_s};
      if (cnt_q != {CNT_W{1'b1}}) cnt_q <= cnt_q + 1'b1;
      if (cnt_q == CNT_W'(7)) begin
        op_q     <= op_next;
        rd_act_q <= (op_next == OP_RDSR);
      end
    end
  end

  // status byte reloaded at every byte boundary
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      miso_q    <= 1'b0;
      out_pos_q <= '0;
      out_sr_q  <= '0;
    end else if (cs_hi) begin
      miso_q    <= 1'b0;
      out_pos_q <= '0;
    end else if (sck_fall && rd_act_q) begin
      out_pos_q <= out_pos_q + 1'b1;
      if (out_pos_q == 3'd0) begin
        miso_q   <= status_i[7];
        out_sr_q <= status_i[6:0];
      end else begin
        miso_q   <= out_sr_q[6];
        out_sr_q <= {out_sr_q[5:0], 1'b0};
      end
    end
  end

  assign miso_o      = miso_q;
  assign cs_hi_o     = cs_hi;
  assign frame_end_o = cs_sync_q[1] & ~cs_sync_q[2];
  assign bit_cnt_o   = cnt_q;
  assign op_o        = op_q;
  assign sector_o    = sr_q[SECT_LSB +: SECT_W];
endmodule

// File: rtl/fes_prot_check.sv
module fes_prot_check #(
  parameter int NUM_SECTORS = 4,
  parameter int SECT_W      = 2
) (
  input  logic [SECT_W-1:0] sector_i,
  input  logic [SECT_W:0]   prot_cnt_i,
  input  logic              prot_top_i,
  output logic              hit_o
);
  logic [31:0] sec_w, cnt_w;

  assign sec_w = 32'(sector_i);
  assign cnt_w = 32'(prot_cnt_i);

  // top-anchored range avoids a subtraction by moving the count across
  always_comb begin
    if (prot_top_i) hit_o = (sec_w + cnt_w) >= 32'(NUM_SECTORS);
    else            hit_o = sec_w < cnt_w;
  end
endmodule

// File: rtl/fes_erase_ctrl.sv
module fes_erase_ctrl
  import fes_pkg::*;
#(
  parameter int NUM_SECTORS = 4,
  parameter int SECT_W      = 2,
  parameter int TSE_CYCLES  = 1000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              frame_end_i,
  input  logic [CNT_W-1:0]  bit_cnt_i,
  input  logic [7:0]        op_i,
  input  logic [SECT_W-1:0] sector_i,
  input  logic [SECT_W:0]   prot_cnt_i,
  input  logic              prot_top_i,
  output logic [7:0]        status_o,
  output logic              wip_o,
  output logic              wel_o,
  output logic              erase_o,
  output logic [SECT_W-1:0] erase_sector_o
);
  localparam int TMR_W = $clog2(TSE_CYCLES + 1);

  erase_state_e      state_q;
  logic              wel_q, hit, wip;
  logic [TMR_W-1:0]  tmr_q;
  logic [SECT_W-1:0] sec_q;
  logic              wren_ok, se_ok;

  fes_prot_check #(
    .NUM_SECTORS(NUM_SECTORS),
    .SECT_W     (SECT_W)
  ) u_prot (
    .sector_i  (sector_i),
    .prot_cnt_i(prot_cnt_i),
    .prot_top_i(prot_top_i),
    .hit_o     (hit)
  );

  assign wren_ok = (op_i == OP_WREN) && (bit_cnt_i == CNT_W'(WREN_BITS));
  assign se_ok   = (op_i == OP_SE) && (bit_cnt_i == CNT_W'(SE_BITS)) && wel_q && !hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      wel_q   <= 1'b0;
      tmr_q   <= '0;
      sec_q   <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (frame_end_i) begin
            if (wren_ok) begin
              wel_q <= 1'b1;
            end else if (se_ok) begin
              state_q <= ST_ERASE;
              tmr_q   <= TMR_W'(TSE_CYCLES - 1);
              sec_q   <= sector_i;
            end
          end
        end
        ST_ERASE: begin
          if (tmr_q == TMR_W'(1)) wel_q <= 1'b0;
          if (tmr_q == '0) state_q <= ST_IDLE;
          else             tmr_q   <= tmr_q - 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign wip            = (state_q == ST_ERASE);
  assign wip_o          = wip;
  assign wel_o          = wel_q;
  assign status_o       = {6'b0, wel_q, wip};
  assign erase_o        = wip && (tmr_q == '0);
  assign erase_sector_o = sec_q;
endmodule

// File: rtl/fes_sector_array.sv
module fes_sector_array #(
  parameter int NUM_SECTORS  = 4,
  parameter int SECTOR_BYTES = 16,
  parameter int SECT_W       = 2,
  parameter int SECT_LSB     = 4,
  parameter int MEM_AW       = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              erase_i,
  input  logic [SECT_W-1:0] sector_i,
  input  logic [MEM_AW-1:0] rd_addr_i,
  output logic [7:0]        rd_data_o
);
  logic [7:0] sec_rd [NUM_SECTORS];

  for (genvar s = 0; s < NUM_SECTORS; s++) begin : g_sector
    logic [7:0] bytes_q [SECTOR_BYTES];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        for (int b = 0; b < SECTOR_BYTES; b++) bytes_q[b] <= 8'h00;
      end else if (erase_i && (sector_i == SECT_W'(s))) begin
        for (int b = 0; b < SECTOR_BYTES; b++) bytes_q[b] <= 8'hFF;
      end
    end

    assign sec_rd[s] = bytes_q[rd_addr_i[SECT_LSB-1:0]];
  end

  assign rd_data_o = sec_rd[rd_addr_i[MEM_AW-1:SECT_LSB]];
endmodule

// File: rtl/flash_erase_slave.sv
module flash_erase_slave
  import fes_pkg::*;
#(
  parameter int NUM_SECTORS  = 4,
  parameter int SECTOR_BYTES = 16,
  parameter int TSE_CYCLES   = 1000,
  localparam int SECT_W      = $clog2(NUM_SECTORS),
  localparam int SECT_LSB    = $clog2(SECTOR_BYTES),
  localparam int MEM_AW      = SECT_W + SECT_LSB
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_n_i,
  input  logic              sck_i,
  input  logic              mosi_i,
  output logic              miso_o,
  input  logic [SECT_W:0]   prot_cnt_i,
  input  logic              prot_top_i,
  input  logic [MEM_AW-1:0] rd_addr_i,
  output logic [7:0]        rd_data_o
);
  logic              cs_hi, frame_end, wip, wel, erase;
  logic [CNT_W-1:0]  bit_cnt;
  logic [7:0]        op, status;
  logic [SECT_W-1:0] sector, erase_sector;

  fes_spi_front #(
    .SECT_LSB(SECT_LSB),
    .SECT_W  (SECT_W)
  ) u_front (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cs_n_i     (cs_n_i),
    .sck_i      (sck_i),
    .mosi_i     (mosi_i),
    .status_i   (status),
    .miso_o     (miso_o),
    .cs_hi_o    (cs_hi),
    .frame_end_o(frame_end),
    .bit_cnt_o  (bit_cnt),
    .op_o       (op),
    .sector_o   (sector)
  );

  fes_erase_ctrl #(
    .NUM_SECTORS(NUM_SECTORS),
    .SECT_W     (SECT_W),
    .TSE_CYCLES (TSE_CYCLES)
  ) u_ctrl (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .frame_end_i   (frame_end),
    .bit_cnt_i     (bit_cnt),
    .op_i          (op),
    .sector_i      (sector),
    .prot_cnt_i    (prot_cnt_i),
    .prot_top_i    (prot_top_i),
    .status_o      (status),
    .wip_o         (wip),
    .wel_o         (wel),
    .erase_o       (erase),
    .erase_sector_o(erase_sector)
  );

  fes_sector_array #(
    .NUM_SECTORS (NUM_SECTORS),
    .SECTOR_BYTES(SECTOR_BYTES),
    .SECT_W      (SECT_W),
    .SECT_LSB    (SECT_LSB),
    .MEM_AW      (MEM_AW)
  ) u_array (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .erase_i  (erase),
    .sector_i (erase_sector),
    .rd_addr_i(rd_addr_i),
    .rd_data_o(rd_data_o)
  );
endmodule

// File: rtl/fes_checker.sv
module fes_checker #(
  parameter int NUM_SECTORS = 4,
  parameter int SECT_W      = 2,
  parameter int TSE_CYCLES  = 1000
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wip,
  input logic              wel,
  input logic              cs_hi,
  input logic              miso_o,
  input logic [SECT_W-1:0] erase_sector,
  input logic [SECT_W:0]   prot_cnt_i,
  input logic              prot_top_i
);
  logic [31:0] busy_cnt_q;
  logic        sec_protected;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  busy_cnt_q <= '0;
    else if (wip) busy_cnt_q <= busy_cnt_q + 1;
    else          busy_cnt_q <= '0;
  end

  assign sec_protected = prot_top_i
      ? (32'(erase_sector) >= 32'(NUM_SECTORS) - 32'(prot_cnt_i))
      : (32'(erase_sector) < 32'(prot_cnt_i));

  p_erase_needs_wel_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wip) |-> $past(wel));

  p_wip_length_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(wip) |-> busy_cnt_q == 32'(TSE_CYCLES));

  p_wel_released_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(wip) |-> !wel);

  p_no_erase_protected_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wip) |-> !sec_protected);

  p_busy_ignores_wren_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wip && $past(wip)) |-> !$rose(wel));

  p_miso_idle_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_hi && $past(cs_hi)) |-> !miso_o);
endmodule

bind flash_erase_slave fes_checker #(
  .NUM_SECTORS(NUM_SECTORS),
  .SECT_W     (SECT_W),
  .TSE_CYCLES (TSE_CYCLES)
) u_fes_checker (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .wip         (wip),
  .wel         (wel),
  .cs_hi       (cs_hi),
  .miso_o      (miso_o),
  .erase_sector(erase_sector),
  .prot_cnt_i  (prot_cnt_i),
  .prot_top_i  (prot_top_i)
);

// File: tb/flash_erase_slave_tb_top.sv
`timescale 1ns/1ps
module flash_erase_slave_tb_top;
  localparam int NS    = 4;
  localparam int SB    = 16;
  localparam int TSE   = 800;
  localparam int SW    = 2;
  localparam int AW    = 6;
  localparam int NB    = NS * SB;
  localparam int H     = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cs_n = 1'b1, sck = 1'b0, mosi = 1'b0;
  logic miso;
  logic [SW:0]   prot_cnt = '0;
  logic          prot_top = 1'b0;
  logic [AW-1:0] rd_addr = '0;
  logic [7:0]    rd_data;

  int cyc = 0, n_checks = 0, n_err = 0, idle_cnt = 0;
  logic [7:0] m_mem [NB];
  bit m_wel = 0, m_pending = 0;
  int fill_at = 0, m_sec = 0;

  flash_erase_slave #(.NUM_SECTORS(NS), .SECTOR_BYTES(SB), .TSE_CYCLES(TSE)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .cs_n_i(cs_n), .sck_i(sck), .mosi_i(mosi),
    .miso_o(miso), .prot_cnt_i(prot_cnt), .prot_top_i(prot_top),
    .rd_addr_i(rd_addr), .rd_data_o(rd_data));

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;
  always @(posedge clk) rd_addr <= rd_addr + 1'b1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  function automatic bit prot_hit(input int s);
    if (prot_top) return s >= NS - int'(prot_cnt);
    return s < int'(prot_cnt);
  endfunction

  // reference model advanced and compared every clock
  always @(negedge clk) begin
    if (rst_n) begin
      if (m_pending && cyc >= fill_at - 1) m_wel = 0;
      if (m_pending && cyc >= fill_at) begin
        for (int b = 0; b < SB; b++) m_mem[m_sec*SB + b] = 8'hFF;
        m_pending = 0;
      end
      chk(rd_data == m_mem[rd_addr], "R8 array byte", rd_data, m_mem[rd_addr]);
      if (cs_n) idle_cnt++; else idle_cnt = 0;
      if (idle_cnt > 4) chk(miso == 1'b0, "R2 idle data out", miso, 0);
    end
  end

  task automatic model_frame(input logic [31:0] data, input int nbits, input int c);
    logic [7:0] op = data[31:24];
    if (m_pending) return;
    if (op == 8'h06 && nbits == 8) m_wel = 1;
    if (op == 8'h20 && nbits == 32 && m_wel) begin
      int s = (int'(data[23:0]) / SB) % NS;
      if (!prot_hit(s)) begin
        m_pending = 1; m_sec = s; fill_at = c + 3 + TSE;
      end
    end
  endtask

  task automatic spi_xfer(input logic [31:0] data, input int nbits, input int rx_bits,
                          output logic [15:0] rx);
    rx = '0;
    @(negedge clk); cs_n = 1'b0;
    repeat (H) @(negedge clk);
    for (int i = 0; i < nbits + rx_bits; i++) begin
      mosi = (i < nbits) ? data[31-i] : 1'b0;
      repeat (H) @(negedge clk);
      sck = 1'b1;
      if (i >= nbits) rx = {rx[14:0], miso};
      repeat (H) @(negedge clk);
      sck = 1'b0;
    end
    repeat (H) @(negedge clk);
    cs_n = 1'b1;
    model_frame(data, nbits, cyc);
    repeat (H) @(negedge clk);
  endtask

  task automatic send(input logic [31:0] data, input int nbits);
    logic [15:0] rx;
    spi_xfer(data, nbits, 0, rx);
  endtask

  task automatic read_status(input string req);
    logic [15:0] rx;
    logic [7:0]  exp;
    exp = {6'b0, m_wel, m_pending};
    spi_xfer({8'h05, 24'h0}, 8, 16, rx);
    chk(rx[15:8] == exp, req, rx[15:8], exp);
    chk(rx[7:0] == exp, {req, " R2 repeat"}, rx[7:0], exp);
  endtask

  task automatic wait_idle();
    while (m_pending) @(negedge clk);
    repeat (10) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++; n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    for (int i = 0; i < NB; i++) m_mem[i] = 8'h00;
    repeat (5) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    repeat (8) @(negedge clk);
    // R11: reset state
    chk(miso == 1'b0, "R11 miso after reset", miso, 0);
    read_status("R11 status after reset");
    // R5: erase with latch clear
    send({8'h20, 24'h000010}, 32);
    repeat (TSE + 20) @(negedge clk);
    read_status("R5 erase without WEL");
    // R4: write-enable one bit long is discarded
    send({8'h06, 1'b0, 23'h0}, 9);
    read_status("R4 long WREN");
    // R1
    send({8'h06, 24'h0}, 8);
    read_status("R1 WEL set");
    // R4: erase one bit short
    send({8'h20, 24'h000010}, 31);
    repeat (TSE + 20) @(negedge clk);
    read_status("R4 short erase keeps WEL");
    // R3/R6: high address bits set, sector 1
    send({8'h20, 24'hF00013}, 32);
    read_status("R6 WIP and WEL during erase");
    wait_idle();
    read_status("R7 WEL cleared after erase");
    // R10: second erase during busy is ignored
    send({8'h06, 24'h0}, 8);
    send({8'h20, 24'h000020}, 32);
    send({8'h20, 24'h000000}, 32);
    send({8'h06, 24'h0}, 8);
    read_status("R10 busy status");
    wait_idle();
    read_status("R10 WREN ignored while busy");
    // R9: top protection of one sector
    prot_top = 1'b1; prot_cnt = 3'd1;
    send({8'h06, 24'h0}, 8);
    send({8'h20, 24'h000030}, 32);
    repeat (TSE + 20) @(negedge clk);
    read_status("R9 top-protected erase keeps WEL");
    send({8'h20, 24'h000005}, 32);
    wait_idle();
    // R9: bottom protection covering all, then three sectors
    prot_top = 1'b0; prot_cnt = 3'd4;
    send({8'h06, 24'h0}, 8);
    send({8'h20, 24'h000031}, 32);
    repeat (TSE + 20) @(negedge clk);
    read_status("R9 bottom full protection");
    prot_cnt = 3'd3;
    send({8'h20, 24'h000031}, 32);
    wait_idle();
    read_status("R9 unprotected sector erased");
    repeat (2 * NB) @(negedge clk);
    finish_run();
  end
endmodule